// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a three-wire serial EEPROM link. A user-side command (read, write, erase, erase-all, write-all, program-enable or program-disable) arrives with a 6-bit word address and a 16-bit word. The controller builds the serial instruction: a start bit, a 2-bit opcode, the address field and, for writes, the data word. It shifts the instruction out on a serial clock whose high and low phases each last a parameter number of system cycles. Data out is held steady across every rising edge.

A read clocks in the device's leading zero and drops it, then collects 16 bits, most significant first. A programming instruction closes chip select on its last falling edge so that the device's self-timed cycle starts. After the minimum low time the controller raises chip select again and watches the device's data line until it reads ready. A counter limits how long it waits. Every instruction is followed by an enforced chip-select low gap. Programming commands are refused locally unless an enable has been run since reset, which mirrors the device's own write-enable latch.

Top module: `uwire_eeprom_host`

## Requirements
- R1: A command code is 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 enable, 6 disable. Each instruction begins with a 1 and is followed by a 2-bit opcode and a 6-bit address, MSB first. The opcodes are read 10, write 01, erase 11, and 00 for the others. For that last group the two top address bits select the operation: enable 11, disable 00, erase-all 10, write-all 01, with the lower address bits 0. Data out changes only while the serial clock is low.
- R2: The serial clock stays low whenever chip select is low. Each clock phase lasts at least DIV system cycles.
- R3: Chip select stays low for at least CSL_CYC system cycles between any two high periods.
- R4: A read takes 25 clock rising edges. The value sampled after the ninth edge is discarded. The following 16 samples form the returned word, MSB first, and `rdata` holds it when `done` pulses.
- R5: Write and write-all send the 16 data bits MSB first after the address, for 25 edges in total. Erase, erase-all, enable and disable use 9 edges.
- R6: A programming command drops chip select together with its last clock fall and waits CSL_CYC cycles. It then raises chip select once more and completes when the device's data line reads 1.
- R7: If ready is not seen within POLL_MAX cycles of polling, the command completes with `err` high.
- R8: Commands 1 to 4 complete on the next cycle with `err` high and no bus activity unless an enable has completed since reset with no later disable. Reads are not affected by this.
- R9: Command code 7 is refused in the same way as a blocked programming command.
- R10: `done` is a one-cycle pulse and `busy` is high from acceptance until that pulse. A `cmd_valid` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Word to write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion status, valid with done |
| rdata | output | 16 | Word returned by a read |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready/busy from the EEPROM |

## Verification
A wrong bit position or slot count in the shifter shows up as wrong read-back data on the very next read of the written address. It also changes the rising-edge count seen by the device model at chip-select fall. A stale write-enable shadow shows up within one cycle as a refused command, or as an accepted one where a refusal was due. A poll or gap counter off by one shows up as a chip-select low period that is too short, measured on the bus, or as an error at the wrong time during a stuck-busy device.

// File: rtl/uwire_eeprom_host.sv
module uwire_eeprom_host #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int DIV      = 2,
  parameter int CSL_CYC  = 4,
  parameter int POLL_MAX = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int HDR  = 3 + ADDR_W;
  localparam int FRM  = HDR + DATA_W;
  localparam int SL_W = $clog2(FRM + 1);
  localparam int DV_W = $clog2(DIV + 1);
  localparam int CN_W = $clog2(POLL_MAX + CSL_CYC + 1);
  localparam int LW   = $clog2(CSL_CYC + 1);

  localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_ER = 3'd2, C_ERAL = 3'd3,
                         C_WRAL = 3'd4, C_EN = 3'd5, C_DIS = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_PWAIT, S_POLL, S_GAP} st_t;

  st_t st;
  logic [2:0]        op_q;
  logic [FRM-1:0]    sh;
  logic [SL_W-1:0]   slot, last;
  logic [DV_W-1:0]   dv;
  logic [CN_W-1:0]   cnt;
  logic [DATA_W-1:0] rd_q;
  logic              wen, cs_q, sk_q, done_q, err_q;

  wire in_prog  = cmd_op inside {C_WR, C_ER, C_ERAL, C_WRAL};
  wire q_prog   = op_q inside {C_WR, C_ER, C_ERAL, C_WRAL};
  wire refuse   = (cmd_op == 3'd7) || (in_prog && !wen);
  wire has_data = (cmd_op == C_WR) || (cmd_op == C_WRAL);
  wire long_frm = has_data || (cmd_op == C_RD);

  logic [1:0]        opc;
  logic [ADDR_W-1:0] af;
  always_comb begin
    opc = 2'b00;
    af  = '0;
    case (cmd_op)
      C_RD:    begin opc = 2'b10; af = cmd_addr; end
      C_WR:    begin opc = 2'b01; af = cmd_addr; end
      C_ER:    begin opc = 2'b11; af = cmd_addr; end
      C_ERAL:  af = {2'b10, {(ADDR_W-2){1'b0}}};
      C_WRAL:  af = {2'b01, {(ADDR_W-2){1'b0}}};
      C_EN:    af = {2'b11, {(ADDR_W-2){1'b0}}};
      default: af = '0;
    endcase
  end

  wire [FRM-1:0] frame = {1'b1, opc, af, has_data ? cmd_wdata : {DATA_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; sh <= '0; slot <= '0; last <= '0; dv <= '0;
      cnt <= '0; rd_q <= '0; wen <= 1'b0; cs_q <= 1'b0; sk_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (refuse) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            op_q  <= cmd_op;
            sh    <= frame;
            slot  <= '0;
            last  <= long_frm ? SL_W'(FRM - 1) : SL_W'(HDR - 1);
            dv    <= '0;
            cs_q  <= 1'b1;
            err_q <= 1'b0;
            st    <= S_LOW;
          end
        end
        S_LOW: if (dv == DV_W'(DIV - 1)) begin
          dv <= '0; sk_q <= 1'b1; st <= S_HIGH;
        end else dv <= dv + 1'b1;
        S_HIGH: if (dv == DV_W'(DIV - 1)) begin
          dv   <= '0;
          sk_q <= 1'b0;
          if (op_q == C_RD && slot >= SL_W'(HDR)) rd_q <= {rd_q[DATA_W-2:0], ee_do};
          if (slot == last) begin
            cs_q <= 1'b0;
            cnt  <= '0;
            if (q_prog) st <= S_PWAIT;
            else begin
              if (op_q == C_EN)  wen <= 1'b1;
              if (op_q == C_DIS) wen <= 1'b0;
              st <= S_GAP;
            end
          end else begin
            slot <= slot + 1'b1;
            sh   <= sh << 1;
            st   <= S_LOW;
          end
        end else dv <= dv + 1'b1;
        S_PWAIT: if (cnt == CN_W'(CSL_CYC - 1)) begin
          cnt <= '0; cs_q <= 1'b1; st <= S_POLL;
        end else cnt <= cnt + 1'b1;
        S_POLL: if (ee_do) begin
          cs_q <= 1'b0; cnt <= '0; st <= S_GAP;
        end else if (cnt == CN_W'(POLL_MAX - 1)) begin
          cs_q <= 1'b0; cnt <= '0; err_q <= 1'b1; st <= S_GAP;
        end else cnt <= cnt + 1'b1;
        S_GAP: if (cnt == CN_W'(CSL_CYC - 1)) begin
          st <= S_IDLE; done_q <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy  = (st != S_IDLE);
  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rd_q;
  assign ee_cs = cs_q;
  assign ee_sk = sk_q;
  assign ee_di = cs_q & sh[FRM-1];

  logic [LW-1:0]   lowcnt;
  logic [DV_W-1:0] phcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt <= LW'(CSL_CYC);
      phcnt  <= DV_W'(DIV);
    end else begin
      if (cs_q) lowcnt <= '0;
      else if (lowcnt < LW'(CSL_CYC)) lowcnt <= lowcnt + 1'b1;
      if (sk_q != $past(sk_q)) phcnt <= DV_W'(1);
      else if (phcnt < DV_W'(DIV)) phcnt <= phcnt + 1'b1;
    end
  end

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> lowcnt >= LW'(CSL_CYC)); // R3
  AST_SK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> !sk_q); // R2
  AST_SK_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sk_q) || $fell(sk_q)) |-> phcnt >= DV_W'(DIV)); // R2
  AST_DI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_q && $past(sk_q)) |-> $stable(ee_di)); // R1
  AST_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && refuse) |=> (done && err && !ee_cs)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

// File: tb/tb_uwire_eeprom_host.sv
`timescale 1ns/1ps
module tb_uwire_eeprom_host;
  localparam int BUSY_CYC = 40;
  localparam int PMAX = 200;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [5:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, done, err, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rdata;

  always #2.5 clk = ~clk;

  uwire_eeprom_host #(.ADDR_W(6), .DATA_W(16), .DIV(2), .CSL_CYC(4), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .err(err), .rdata(rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  // device model, evaluated at negedge
  logic [15:0] m_mem [64];
  logic        m_started, m_reading, m_rbit, m_wen, stuck;
  int          m_bits, m_rcnt, m_pend, m_busy;
  logic [23:0] m_sr;
  logic [1:0]  m_opc;
  logic [5:0]  m_addr;
  logic [15:0] m_rdat, m_wd;
  logic        prev_cs, prev_sk, prev_di;
  int edges, rises, lowcnt, phcnt, viol_di, viol_ph, viol_cs;

  assign ee_do = ee_cs ? (m_reading ? m_rbit : (m_busy == 0)) : 1'b1;

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
    m_started = 0; m_reading = 0; m_rbit = 0; m_wen = 0; stuck = 0;
    m_bits = 0; m_rcnt = 0; m_pend = 0; m_busy = 0; m_sr = '0; m_opc = '0;
    m_addr = '0; m_rdat = '0; m_wd = '0;
    prev_cs = 0; prev_sk = 0; prev_di = 0;
    edges = 0; rises = 0; lowcnt = 1000; phcnt = 1000; viol_di = 0; viol_ph = 0; viol_cs = 0;
  end

  always @(negedge clk) begin
    if (m_busy > 0) m_busy = m_busy - 1;
    if (!stuck && m_busy > BUSY_CYC) m_busy = BUSY_CYC;
    if (ee_sk && prev_sk && ee_di != prev_di) viol_di++;
    if (ee_sk != prev_sk) begin
      if (phcnt < 2) viol_ph++;
      phcnt = 1;
    end else phcnt++;
    if (ee_cs && !prev_cs) begin
      rises++;
      if (lowcnt < 4) viol_cs++;
    end
    if (ee_cs) lowcnt = 0; else lowcnt++;
    if (!ee_cs) begin
      if (prev_cs && m_pend != 0 && m_wen) begin
        case (m_pend)
          1: m_mem[m_addr] = m_wd;
          2: m_mem[m_addr] = 16'hFFFF;
          3: for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
          default: for (int i = 0; i < 64; i++) m_mem[i] = m_wd;
        endcase
        m_busy = stuck ? 100000000 : BUSY_CYC;
      end
      m_pend = 0; m_started = 0; m_reading = 0; m_bits = 0;
    end else if (ee_sk && !prev_sk) begin
      edges++;
      if (!m_started) begin
        if (ee_di) begin m_started = 1; m_bits = 0; end
      end else begin
        m_sr = {m_sr[22:0], ee_di};
        m_bits++;
        if (m_reading) begin
          m_rbit = m_rdat[15 - m_rcnt];
          m_rcnt++;
        end
        if (m_bits == 8) begin
          m_opc = m_sr[7:6]; m_addr = m_sr[5:0];
          case (m_opc)
            2'b10: begin m_reading = 1; m_rdat = m_mem[m_addr]; m_rbit = 0; m_rcnt = 0; end
            2'b11: m_pend = 2;
            2'b00: case (m_addr[5:4])
              2'b11: m_wen = 1;
              2'b00: m_wen = 0;
              2'b10: m_pend = 3;
              default: ;
            endcase
            default: ;
          endcase
        end
        if (m_bits == 24 && !m_reading) begin
          m_wd = m_sr[15:0];
          if (m_opc == 2'b01) m_pend = 1;
          else if (m_opc == 2'b00 && m_addr[5:4] == 2'b01) m_pend = 4;
        end
      end
    end
    prev_cs = ee_cs; prev_sk = ee_sk; prev_di = ee_di;
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic r_err;
  logic [15:0] r_data;
  int d_edges, d_rises, r_cyc;

  task automatic run_cmd(input logic [2:0] op, input logic [5:0] a, input logic [15:0] wd);
    int e0, s0;
    e0 = edges; s0 = rises; r_cyc = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    while (!done && r_cyc < 5000) begin @(negedge clk); r_cyc++; end
    r_err = err; r_data = rdata;
    repeat (2) @(negedge clk);
    d_edges = edges - e0; d_rises = rises - s0;
  endtask

  localparam int NV = 21;
  localparam logic [41:0] VEC [NV] = '{
    {3'd1, 6'd5,  16'h1234, 1'b1, 16'h0000},
    {3'd0, 6'd5,  16'h0000, 1'b0, 16'hFFFF},
    {3'd5, 6'd0,  16'h0000, 1'b0, 16'h0000},
    {3'd1, 6'd5,  16'hA5C3, 1'b0, 16'h0000},
    {3'd0, 6'd5,  16'h0000, 1'b0, 16'hA5C3},
    {3'd1, 6'd63, 16'h8001, 1'b0, 16'h0000},
    {3'd0, 6'd63, 16'h0000, 1'b0, 16'h8001},
    {3'd0, 6'd0,  16'h0000, 1'b0, 16'hFFFF},
    {3'd2, 6'd5,  16'h0000, 1'b0, 16'h0000},
    {3'd0, 6'd5,  16'h0000, 1'b0, 16'hFFFF},
    {3'd4, 6'd0,  16'h3C5A, 1'b0, 16'h0000},
    {3'd0, 6'd17, 16'h0000, 1'b0, 16'h3C5A},
    {3'd3, 6'd0,  16'h0000, 1'b0, 16'h0000},
    {3'd0, 6'd63, 16'h0000, 1'b0, 16'hFFFF},
    {3'd1, 6'd0,  16'h0001, 1'b0, 16'h0000},
    {3'd6, 6'd0,  16'h0000, 1'b0, 16'h0000},
    {3'd2, 6'd0,  16'h0000, 1'b1, 16'h0000},
    {3'd0, 6'd0,  16'h0000, 1'b0, 16'h0001},
    {3'd7, 6'd0,  16'h0000, 1'b1, 16'h0000},
    {3'd4, 6'd0,  16'hBEEF, 1'b1, 16'h0000},
    {3'd0, 6'd40, 16'h0000, 1'b0, 16'hFFFF}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!ee_cs && !ee_sk && !busy && !done, "R10 reset idle", {ee_cs, ee_sk, busy, done}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic rej; int ee, er;
      op = VEC[i][41:39];
      run_cmd(op, VEC[i][38:33], VEC[i][32:17]);
      rej = VEC[i][16];
      chk(r_err == rej, "R8/R9 err status", r_err, rej);
      if (op == 3'd0) chk(r_data == VEC[i][15:0], "R4 read data", r_data, VEC[i][15:0]);
      ee = rej ? 0 : ((op == 3'd0 || op == 3'd1 || op == 3'd4) ? 25 : 9);
      er = rej ? 0 : ((op inside {3'd1, 3'd2, 3'd3, 3'd4}) ? 2 : 1);
      chk(d_edges == ee, "R5 clock edge count", d_edges, ee);
      chk(d_rises == er, "R6 chip-select rises", d_rises, er);
      if (rej) chk(r_cyc == 0, "R8 immediate refuse", r_cyc, 0);
    end

    // R7 timeout with a device that never gets ready
    run_cmd(3'd5, 0, 0);
    stuck = 1;
    run_cmd(3'd1, 6'd9, 16'h5A5A);
    chk(r_err == 1'b1, "R7 poll timeout err", r_err, 1);
    chk(r_cyc >= PMAX, "R7 timeout length", r_cyc, PMAX);
    stuck = 0;
    repeat (BUSY_CYC + 5) @(negedge clk);
    run_cmd(3'd0, 6'd9, 0);
    chk(r_data == 16'h5A5A, "R7 write landed", r_data, 16'h5A5A);

    // R10 request while busy is ignored
    begin
      int s0;
      s0 = rises;
      @(negedge clk);
      cmd_valid = 1; cmd_op = 3'd0; cmd_addr = 6'd9;
      @(negedge clk);
      cmd_valid = 1; cmd_op = 3'd3;
      repeat (5) @(negedge clk);
      cmd_valid = 0;
      chk(busy == 1'b1, "R10 busy during command", busy, 1);
      while (!done) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(rises - s0 == 1, "R10 extra request ignored", rises - s0, 1);
      run_cmd(3'd0, 6'd9, 0);
      chk(r_data == 16'h5A5A, "R10 memory intact", r_data, 16'h5A5A);
    end

    chk(viol_di == 0, "R1 data stable while clock high", viol_di, 0);
    chk(viol_ph == 0, "R2 clock phase width", viol_ph, 0);
    chk(viol_cs == 0, "R3 chip-select low gap", viol_cs, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule